// File: doc/BRIEF.md
# Write-Burst Dynamic Termination Controller

This block picks, clock by clock, the termination setting that a memory device's data pins present. Two settings are configured from outside: a nominal value with its enable and a write value with its enable. Each write command opens a write window. While the window is open the write setting takes over. When the window closes the nominal setting comes back. No configuration write is needed for the change; it follows the write commands alone.

The window is four clocks long. With burst chop it is still four clocks, because a chopped burst keeps full-burst timing. A write command that lands inside an open window restarts the window, so back-to-back writes never drop to the nominal setting in between. Two conditions force termination off whatever else is happening: DLL-off operation, and the active-low reset. The outputs are registered. When termination is off, the reported value is zero.

Top module: `dyn_term_ctrl`

## Requirements
- R1: With the write enable set, a write command sampled at clock edge k makes `term_on`=1 and `term_val`=`wr_val` after edges k through k+3, which is four cycles.
- R2: With the nominal enable set and no window open, `term_on`=1 and `term_val`=`nom_val`; this includes the first cycle after a window ends, which is after edge k+4.
- R3: With only the write enable set, termination is on only inside the write window; outside it `term_on`=0 and `term_val`=0.
- R4: `burst_chop`=1 does not change the window length, which stays four cycles.
- R5: `dll_off`=1 sampled at an edge forces `term_on`=0 and `term_val`=0 after that edge. The window keeps counting, so output resumes correctly once `dll_off` clears.
- R6: `rst_n`=0 forces `term_on`=0 and `term_val`=0 at once, without waiting for a clock, and clears any open window.
- R7: A write command sampled while a window is open restarts the full four-cycle window.
- R8: With only the nominal enable set, the nominal value stays in effect through write windows.
- R9: With neither enable set, `term_on` stays 0 whatever write commands arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nom_val | input | VAL_W | Nominal termination value |
| nom_en | input | 1 | Nominal termination enable |
| wr_val | input | VAL_W | Write termination value |
| wr_en | input | 1 | Write termination enable |
| wr_cmd | input | 1 | Write command strobe, one cycle per command |
| burst_chop | input | 1 | 1 = chopped burst for this command |
| dll_off | input | 1 | 1 = DLL-off operation, termination unsupported |
| term_val | output | VAL_W | Termination value in effect (0 when off) |
| term_on | output | 1 | Termination active |

## Verification
The main function is driven under all four enable combinations.
- Both enables set: separates the write value from the nominal value and shows the exact cycle on which the setting returns.
- Only the write enable set: separates "off" from "nominal" outside the window.
- Only the nominal enable set: shows that a write command alone changes nothing.
- Neither enable set: shows that commands cannot turn termination on.

Further sequences cover the remaining cases:
- Back-to-back commands tell a restarted window from a window that ran out early.
- A chopped-burst command tells the four-cycle window from a shorter one.
- A DLL-off stretch shows the output held off while the window keeps counting in the background.
- A reset during an open window shows the output clearing at once and no window left afterwards.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    // Source of the termination setting chosen for the next cycle
    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_NOM = 2'd1,
        SRC_WR  = 2'd2
    } term_src_e;

endpackage

// File: rtl/dtc_window.sv
module dtc_window #(
    parameter int WIN_BL8 = 4,
    parameter int WIN_BC4 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cmd,
    input  logic burst_chop,
    output logic win_d
);
    localparam int WIN_MAX = (WIN_BL8 > WIN_BC4) ? WIN_BL8 : WIN_BC4;
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cmd) begin
            st_d.cnt = burst_chop ? CNT_W'(WIN_BC4) : CNT_W'(WIN_BL8);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    assign win_d = (st_d.cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7 / R4: each command loads the full window for its burst type
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> st_q.cnt == ($past(burst_chop) ? CNT_W'(WIN_BC4) : CNT_W'(WIN_BL8)));

    // R1: an open window counts down one step per clock without a new command
    p_countdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && !wr_cmd) |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1));

endmodule

// File: rtl/dtc_select.sv
module dtc_select
    import dtc_pkg::*;
(
    input  logic      win,
    input  logic      nom_en,
    input  logic      wr_en,
    input  logic      dll_off,
    output term_src_e src
);
    always_comb begin
        if (dll_off) begin
            src = SRC_OFF;
        end else if (win && wr_en) begin
            src = SRC_WR;
        end else if (nom_en) begin
            src = SRC_NOM;
        end else begin
            src = SRC_OFF;
        end
    end

    // R5: DLL-off operation never selects a driving setting
    always_comb begin
        if (dll_off) begin
            a_dll_sel_r5: assert (src == SRC_OFF);
        end
    end

endmodule

// File: rtl/dyn_term_ctrl.sv
module dyn_term_ctrl
    import dtc_pkg::*;
#(
    parameter int VAL_W   = 3,
    parameter int WIN_BL8 = 4,
    parameter int WIN_BC4 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] nom_val,
    input  logic             nom_en,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic             burst_chop,
    input  logic             dll_off,
    output logic [VAL_W-1:0] term_val,
    output logic             term_on
);
    typedef struct packed {
        logic             on;
        logic [VAL_W-1:0] val;
    } out_state_t;

    logic      win_next;
    term_src_e src;
    out_state_t out_d, out_q;

    dtc_window #(
        .WIN_BL8 (WIN_BL8),
        .WIN_BC4 (WIN_BC4)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_cmd),
        .burst_chop (burst_chop),
        .win_d      (win_next)
    );

    dtc_select u_select (
        .win     (win_next),
        .nom_en  (nom_en),
        .wr_en   (wr_en),
        .dll_off (dll_off),
        .src     (src)
    );

    always_comb begin
        out_d = '0;
        unique case (src)
            SRC_WR: begin
                out_d.on  = 1'b1;
                out_d.val = wr_val;
            end
            SRC_NOM: begin
                out_d.on  = 1'b1;
                out_d.val = nom_val;
            end
            default: begin
                out_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign term_on  = out_q.on;
    assign term_val = out_q.val;

    // R1: a write command with write termination enabled drives the write value next cycle
    p_wr_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wr_en && !dll_off) |=> (term_on && term_val == $past(wr_val)));

    // R5: DLL-off operation holds termination off
    p_dll_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dll_off |=> (!term_on && term_val == '0));

    // R9: with both enables clear nothing turns termination on
    p_none_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!nom_en && !wr_en) |=> !term_on);

    // R8: nominal-only setup keeps the nominal value even through writes
    p_nom_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nom_en && !wr_en && !dll_off) |=> (term_on && term_val == $past(nom_val)));

endmodule

// File: tb/dyn_term_ctrl_tb.sv
`timescale 1ns/1ps
module dyn_term_ctrl_tb;
    localparam int VAL_W = 3;
    localparam int NVEC  = 36;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VAL_W-1:0] nom_val = 3'd2;
    logic             nom_en = 1'b0;
    logic [VAL_W-1:0] wr_val = 3'd5;
    logic             wr_en = 1'b0;
    logic             wr_cmd = 1'b0;
    logic             burst_chop = 1'b0;
    logic             dll_off = 1'b0;
    logic [VAL_W-1:0] term_val;
    logic             term_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dyn_term_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .nom_val    (nom_val),
        .nom_en     (nom_en),
        .wr_val     (wr_val),
        .wr_en      (wr_en),
        .wr_cmd     (wr_cmd),
        .burst_chop (burst_chop),
        .dll_off    (dll_off),
        .term_val   (term_val),
        .term_on    (term_on)
    );

    // Vector: {req[3:0], cmd, chop, dll, nom_en, wr_en, exp_on, exp_val[2:0]}
    // nom_val = 2, wr_val = 5 throughout the table.
    localparam logic [12:0] VEC [NVEC] = '{
        {4'd2, 5'b00011, 1'b1, 3'd2},  // R2 idle nominal
        {4'd1, 5'b10011, 1'b1, 3'd5},  // R1 start
        {4'd1, 5'b00011, 1'b1, 3'd5},
        {4'd1, 5'b00011, 1'b1, 3'd5},
        {4'd1, 5'b00011, 1'b1, 3'd5},
        {4'd2, 5'b00011, 1'b1, 3'd2},  // R2 return after four
        {4'd7, 5'b10011, 1'b1, 3'd5},  // R7 back-to-back
        {4'd7, 5'b00011, 1'b1, 3'd5},
        {4'd7, 5'b10011, 1'b1, 3'd5},
        {4'd7, 5'b00011, 1'b1, 3'd5},
        {4'd7, 5'b00011, 1'b1, 3'd5},
        {4'd7, 5'b00011, 1'b1, 3'd5},
        {4'd7, 5'b00011, 1'b1, 3'd2},
        {4'd4, 5'b11011, 1'b1, 3'd5},  // R4 chopped burst
        {4'd4, 5'b01011, 1'b1, 3'd5},
        {4'd4, 5'b01011, 1'b1, 3'd5},
        {4'd4, 5'b01011, 1'b1, 3'd5},
        {4'd4, 5'b01011, 1'b1, 3'd2},
        {4'd3, 5'b00001, 1'b0, 3'd0},  // R3 write-only idle
        {4'd3, 5'b10001, 1'b1, 3'd5},
        {4'd3, 5'b00001, 1'b1, 3'd5},
        {4'd3, 5'b00001, 1'b1, 3'd5},
        {4'd3, 5'b00001, 1'b1, 3'd5},
        {4'd3, 5'b00001, 1'b0, 3'd0},
        {4'd9, 5'b10000, 1'b0, 3'd0},  // R9 neither enabled
        {4'd9, 5'b00000, 1'b0, 3'd0},
        {4'd9, 5'b00000, 1'b0, 3'd0},
        {4'd9, 5'b00000, 1'b0, 3'd0},
        {4'd9, 5'b00000, 1'b0, 3'd0},
        {4'd8, 5'b10010, 1'b1, 3'd2},  // R8 nominal-only
        {4'd8, 5'b00010, 1'b1, 3'd2},
        {4'd5, 5'b10111, 1'b0, 3'd0},  // R5 dll off
        {4'd5, 5'b00111, 1'b0, 3'd0},
        {4'd5, 5'b00111, 1'b0, 3'd0},
        {4'd5, 5'b00111, 1'b0, 3'd0},
        {4'd5, 5'b00011, 1'b1, 3'd2}   // R5 window expired in background
    };

    task automatic check(input int req, input logic exp_on, input logic [VAL_W-1:0] exp_val);
        n_chk++;
        if (term_on !== exp_on || term_val !== exp_val) begin
            n_bad++;
            $display("FAIL R%0d: got on=%0b val=%0d, expected on=%0b val=%0d",
                     req, term_on, term_val, exp_on, exp_val);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R6 reset state
        #7;
        check(6, 1'b0, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wr_cmd     = VEC[i][8];
            burst_chop = VEC[i][7];
            dll_off    = VEC[i][6];
            nom_en     = VEC[i][5];
            wr_en      = VEC[i][4];
            @(posedge clk);
            #1;
            check(int'(VEC[i][12:9]), VEC[i][3], VEC[i][2:0]);
        end

        // R1 with a different write value
        @(negedge clk);
        wr_val = 3'd7; wr_cmd = 1'b1; nom_en = 1'b1; wr_en = 1'b1; dll_off = 1'b0; burst_chop = 1'b0;
        @(posedge clk); #1;
        check(1, 1'b1, 3'd7);

        // R6 asynchronous reset during an open window
        @(negedge clk);
        wr_cmd = 1'b0;
        #0.5;
        rst_n = 1'b0;
        #0.5;
        check(6, 1'b0, 3'd0);
        @(posedge clk); #1;
        check(6, 1'b0, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        nom_val = 3'd6;
        @(posedge clk); #1;
        check(6, 1'b1, 3'd6);   // window cleared: nominal, not write value (R2)
        @(posedge clk); #1;
        check(2, 1'b1, 3'd6);

        finish_run();
    end

endmodule